// File: doc/BRIEF.md
# Bus Transfer Snapshot with Halt on Error

This block watches a parallel backplane bus and keeps a copy of the most recent completed transfer in three registers. The address register holds the address lines, with bit 0 read as zero. The data register holds the data lines. The control register holds the acknowledge, strobe, direction, width and interrupt-acknowledge lines together with the address modifier. A transfer counts as finished when its acknowledge (data acknowledge or bus error) is released. If a transfer ends its data strobes without any acknowledge, the strobe release closes it instead. In both cases the stored values are those present on the bus in the last clock before the closing edge.

Software can freeze the snapshot by setting a halt bit in a small control register. When halt-on-error is enabled, a transfer that ends in a bus error is stored and the block then enters a hardware halt. The halt keeps the snapshot frozen until the reset-halt request goes from low to high. Each operating mode is the OR of a front switch input and the matching control bit. A status word reports the switches, the control bits and a health flag built from clock and supply indications.

Top module: `xfer_snapshot`

## Requirements
- R1: When DTACK or BERR goes from asserted to released and the snapshot is not frozen, all three registers load the bus values sampled in the last clock in which the acknowledge was asserted. The load is visible one clock after the release is seen.
- R2: When DS0 or DS1 ends (neither of them is still asserted) and no acknowledge was seen since that strobe began, the registers load the values from the last clock in which a strobe was asserted. A transfer that was acknowledged is captured exactly once, even when its strobes end after the acknowledge.
- R3: The control register holds, from bit 15 down to bit 0: IACK, IACKIN, IACKOUT, DTACK, BERR, AS, DS0, DS1, WRITE, LWORD, then the address modifier bits 5..0. Every line is stored as 1 when asserted.
- R4: While the hardware halt is active, or while control bit 7 (software halt) is 1, no transfer changes any of the three registers.
- R5: A transfer that ends by release of BERR is stored and then sets `haltActive` on the same clock, provided that mode bit 2 (halt enable) is effective. With halt enable off, or when the transfer did not end in a bus error, `haltActive` stays 0.
- R6: Only a 0-to-1 change of effective mode bit 3 (reset halt) clears `haltActive`. A request held high clears the halt only once, and a bus error that occurs while the request is still high halts the block again and keeps it halted.
- R7: `modeEff` bit i equals `swMode[i]` OR control bit i, for the bits 0 responder, 1 display-all, 2 halt enable, 3 reset halt, 4 enable-data. A control write stores bits 7 and 4..0 only. Bits 6..5 always read back as 0.
- R8: `statusWord` is {health, 2'b00, swMode[4:0], control[7:0]}, where health = clkOk & p5Ok & p12Ok & n12Ok & ~p5Over.
- R9: Asserting `rstN` low clears the three capture registers, the control register and the hardware halt.
- R10: Bit 0 of `capAddr` is always 0. Bits 31..1 follow address lines 31..1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| busAddr | input | 31 | Address lines 31..1 |
| busData | input | 32 | Data lines 31..0 |
| busAm | input | 6 | Address modifier lines |
| lnIack | input | 1 | Interrupt acknowledge asserted |
| lnIackIn | input | 1 | Interrupt acknowledge daisy input asserted |
| lnIackOut | input | 1 | Interrupt acknowledge daisy output asserted |
| lnDtack | input | 1 | Data acknowledge asserted |
| lnBerr | input | 1 | Bus error asserted |
| lnAs | input | 1 | Address strobe asserted |
| lnDs0 | input | 1 | Data strobe 0 asserted |
| lnDs1 | input | 1 | Data strobe 1 asserted |
| lnWrite | input | 1 | Write direction asserted |
| lnLword | input | 1 | Long-word width asserted |
| swMode | input | 5 | Switch mode inputs (see R7) |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 8 | Control register write value |
| clkOk | input | 1 | System clock present |
| p5Ok | input | 1 | +5 V above its low limit |
| p12Ok | input | 1 | +12 V above its low limit |
| n12Ok | input | 1 | -12 V below its limit |
| p5Over | input | 1 | +5 V overvoltage |
| capAddr | output | 32 | Captured address |
| capData | output | 32 | Captured data |
| capCtrl | output | 16 | Captured control word |
| statusWord | output | 16 | Status word |
| modeEff | output | 5 | Effective modes |
| haltActive | output | 1 | Hardware halt indicator |

## Verification
The bench closes transfers in four ways: by DTACK release, by BERR release, by strobe end alone, and by an acknowledge released before the strobes. After each close it changes the bus lines, so a design that captured at the wrong edge, or captured one clock late, stores garbage. In the last case a design that also captured at the later strobe end overwrites the good snapshot. Frozen periods, software or hardware, are followed by transfers whose values must not appear. A reset-halt request is held across a fresh bus error: a design that reacts to the level rather than the edge would fail to stay halted. Halt enable is driven from the switch and from the control bit separately, so a design that ignores either source of the OR misses a halt.

// File: rtl/snap_pkg.sv
package snap_pkg;

  localparam int FLAG_W        = 10;
  localparam int MODE_RESP     = 0;
  localparam int MODE_ALL      = 1;
  localparam int MODE_HALTEN   = 2;
  localparam int MODE_RSTHALT  = 3;
  localparam int MODE_DATA     = 4;
  localparam int SOFT_HALT_BIT = 7;

  // Order from msb to lsb is the control word layout above the AM field.
  typedef struct packed {
    logic iack;
    logic iackIn;
    logic iackOut;
    logic dtack;
    logic berr;
    logic as;
    logic ds0;
    logic ds1;
    logic write;
    logic lword;
  } busFlags_t;

  typedef struct packed {
    logic capture;
  } snapStrobe_t;

  typedef enum logic {
    ST_ARMED  = 1'b0,
    ST_HALTED = 1'b1
  } haltState_t;

endpackage

// File: rtl/snap_dp.sv
module snap_dp
  import snap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int AM_W   = 6
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  snapStrobe_t            strobe,
  input  logic [ADDR_W-1:1]      busAddr,
  input  logic [DATA_W-1:0]      busData,
  input  logic [AM_W-1:0]        busAm,
  input  busFlags_t              busFlags,
  output logic                   prevAck,
  output logic                   prevStr,
  output logic                   prevBerr,
  output logic [ADDR_W-1:0]      addrQ,
  output logic [DATA_W-1:0]      dataQ,
  output logic [FLAG_W+AM_W-1:0] ctrlQ
);

  // One-clock history of the bus: this is what a capture stores.
  logic [ADDR_W-1:1] addrS;
  logic [DATA_W-1:0] dataS;
  logic [AM_W-1:0]   amS;
  busFlags_t         flagsS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrS  <= '0;
      dataS  <= '0;
      amS    <= '0;
      flagsS <= '0;
    end else begin
      addrS  <= busAddr;
      dataS  <= busData;
      amS    <= busAm;
      flagsS <= busFlags;
    end
  end

  assign prevAck  = flagsS.dtack | flagsS.berr;
  assign prevStr  = flagsS.ds0 | flagsS.ds1;
  assign prevBerr = flagsS.berr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      ctrlQ <= '0;
    end else if (strobe.capture) begin
      addrQ <= {addrS, 1'b0};
      dataQ <= dataS;
      ctrlQ <= {flagsS, amS};
    end
  end

  // R10: the lowest address bit never holds a one
  p_addr_lsb_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (addrQ[0] == 1'b0));

endmodule

// File: rtl/snap_ctrl.sv
module snap_ctrl
  import snap_pkg::*;
#(
  parameter int MODE_W = 5,
  parameter int CREG_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              nowAck,
  input  logic              nowStr,
  input  logic              prevAck,
  input  logic              prevStr,
  input  logic              prevBerr,
  input  logic [MODE_W-1:0] swMode,
  input  logic              ctrlWe,
  input  logic [CREG_W-1:0] ctrlWdata,
  output snapStrobe_t       strobe,
  output logic              halted,
  output logic              softHalt,
  output logic [MODE_W-1:0] modeEff,
  output logic [CREG_W-1:0] ctrlReg
);

  localparam logic [CREG_W-1:0] WR_MASK =
    CREG_W'((1 << MODE_W) - 1) | CREG_W'(1 << SOFT_HALT_BIT);

  haltState_t state;
  logic ackSeen;
  logic rhPrev;
  logic ackFall, strFall, cycleEnd, rhRise;

  // Software control register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       ctrlReg <= '0;
    else if (ctrlWe) ctrlReg <= ctrlWdata & WR_MASK;
  end

  for (genvar i = 0; i < MODE_W; i++) begin : g_mode
    assign modeEff[i] = swMode[i] | ctrlReg[i];
  end

  assign softHalt = ctrlReg[SOFT_HALT_BIT];

  // Transfer boundary detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   ackSeen <= 1'b0;
    else if (nowAck)             ackSeen <= 1'b1;
    else if (!nowStr)            ackSeen <= 1'b0;
  end

  assign ackFall  = prevAck & ~nowAck;
  assign strFall  = prevStr & ~nowStr & ~ackSeen & ~nowAck;
  assign cycleEnd = ackFall | strFall;

  assign halted         = (state == ST_HALTED);
  assign strobe.capture = cycleEnd & ~halted & ~softHalt;

  // Halt state machine; release acts on the rising edge only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rhPrev <= 1'b0;
    else       rhPrev <= modeEff[MODE_RSTHALT];
  end

  assign rhRise = modeEff[MODE_RSTHALT] & ~rhPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_ARMED;
    end else begin
      unique case (state)
        ST_ARMED:
          if (strobe.capture && ackFall && prevBerr && modeEff[MODE_HALTEN])
            state <= ST_HALTED;
        ST_HALTED:
          if (rhRise) state <= ST_ARMED;
        default: state <= ST_ARMED;
      endcase
    end
  end

  p_no_double_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> !strobe.capture);

  p_halt_on_berr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && strobe.capture && prevBerr && modeEff[MODE_HALTEN]) |=> halted);

  p_no_spurious_halt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && !(strobe.capture && prevBerr)) |=> !halted);

  p_release_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    (halted && rhPrev) |=> halted);

endmodule

// File: rtl/xfer_snapshot.sv
module xfer_snapshot
  import snap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int AM_W   = 6,
  parameter int MODE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:1] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [AM_W-1:0]   busAm,
  input  logic              lnIack,
  input  logic              lnIackIn,
  input  logic              lnIackOut,
  input  logic              lnDtack,
  input  logic              lnBerr,
  input  logic              lnAs,
  input  logic              lnDs0,
  input  logic              lnDs1,
  input  logic              lnWrite,
  input  logic              lnLword,
  input  logic [MODE_W-1:0] swMode,
  input  logic              ctrlWe,
  input  logic [7:0]        ctrlWdata,
  input  logic              clkOk,
  input  logic              p5Ok,
  input  logic              p12Ok,
  input  logic              n12Ok,
  input  logic              p5Over,
  output logic [ADDR_W-1:0] capAddr,
  output logic [DATA_W-1:0] capData,
  output logic [FLAG_W+AM_W-1:0] capCtrl,
  output logic [15:0]       statusWord,
  output logic [MODE_W-1:0] modeEff,
  output logic              haltActive
);

  localparam int CREG_W = 8;
  localparam int PAD_W  = 16 - 1 - MODE_W - CREG_W;

  busFlags_t   lineNow;
  snapStrobe_t strobe;
  logic prevAck, prevStr, prevBerr;
  logic nowAck, nowStr;
  logic softHalt;
  logic [CREG_W-1:0] ctrlReg;
  logic health;

  assign lineNow = {lnIack, lnIackIn, lnIackOut, lnDtack, lnBerr,
                    lnAs, lnDs0, lnDs1, lnWrite, lnLword};
  assign nowAck  = lnDtack | lnBerr;
  assign nowStr  = lnDs0 | lnDs1;

  snap_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AM_W(AM_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .busAddr(busAddr), .busData(busData), .busAm(busAm), .busFlags(lineNow),
    .prevAck(prevAck), .prevStr(prevStr), .prevBerr(prevBerr),
    .addrQ(capAddr), .dataQ(capData), .ctrlQ(capCtrl)
  );

  snap_ctrl #(.MODE_W(MODE_W), .CREG_W(CREG_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .nowAck(nowAck), .nowStr(nowStr),
    .prevAck(prevAck), .prevStr(prevStr), .prevBerr(prevBerr),
    .swMode(swMode), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .strobe(strobe), .halted(haltActive), .softHalt(softHalt),
    .modeEff(modeEff), .ctrlReg(ctrlReg)
  );

  assign health     = clkOk & p5Ok & p12Ok & n12Ok & ~p5Over;
  assign statusWord = {health, {PAD_W{1'b0}}, swMode, ctrlReg};

  p_ack_capture_r1: assert property (@(posedge clk) disable iff (!rstN)
    (prevAck && !nowAck && !haltActive && !softHalt)
      |=> (capCtrl[AM_W+FLAG_W-4] || capCtrl[AM_W+FLAG_W-5]));

  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (haltActive || softHalt)
      |=> ($stable(capAddr) && $stable(capData) && $stable(capCtrl)));

endmodule

// File: tb/sim_xfer_snapshot.sv
module sim_xfer_snapshot;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:1] busAddr = '0;
  logic [31:0] busData = '0;
  logic [5:0]  busAm = '0;
  logic lnIack = 0, lnIackIn = 0, lnIackOut = 0, lnDtack = 0, lnBerr = 0;
  logic lnAs = 0, lnDs0 = 0, lnDs1 = 0, lnWrite = 0, lnLword = 0;
  logic [4:0] swMode = '0;
  logic ctrlWe = 0;
  logic [7:0] ctrlWdata = '0;
  logic clkOk = 1, p5Ok = 1, p12Ok = 1, n12Ok = 1, p5Over = 0;
  logic [31:0] capAddr, capData;
  logic [15:0] capCtrl, statusWord;
  logic [4:0]  modeEff;
  logic        haltActive;

  always #10 clk = ~clk;

  xfer_snapshot u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busData(busData), .busAm(busAm),
    .lnIack(lnIack), .lnIackIn(lnIackIn), .lnIackOut(lnIackOut),
    .lnDtack(lnDtack), .lnBerr(lnBerr), .lnAs(lnAs), .lnDs0(lnDs0), .lnDs1(lnDs1),
    .lnWrite(lnWrite), .lnLword(lnLword), .swMode(swMode),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .clkOk(clkOk), .p5Ok(p5Ok), .p12Ok(p12Ok), .n12Ok(n12Ok), .p5Over(p5Over),
    .capAddr(capAddr), .capData(capData), .capCtrl(capCtrl),
    .statusWord(statusWord), .modeEff(modeEff), .haltActive(haltActive)
  );

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] eAddr = '0, eData = '0;
  logic [15:0] eCtrl = '0;
  logic        eHalt = 1'b0;
  logic [7:0]  eCreg = '0;
  logic [4:0]  eSw = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrlWordOf(input logic [2:0] iackBits, input logic dt,
      input logic be, input logic as, input logic d0, input logic d1,
      input logic wr, input logic lw, input logic [5:0] am);
    return {iackBits, dt, be, as, d0, d1, wr, lw, am};
  endfunction

  task automatic checkAll(input string tag);
    chk({tag, " addr R1 R10"}, capAddr, eAddr);
    chk({tag, " data R1"}, capData, eData);
    chk({tag, " ctrl R3"}, {16'h0, capCtrl}, {16'h0, eCtrl});
    chk({tag, " halt R5 R6"}, {31'h0, haltActive}, {31'h0, eHalt});
  endtask

  // kind: 0 dtack, 1 berr, 2 no acknowledge, 3 acknowledge released before strobes
  task automatic busCycle(input int kind, input logic [31:0] a, input logic [31:0] d,
      input logic [5:0] am, input logic [2:0] ib, input logic wr, input logic lw,
      input logic [1:0] ds);
    logic [15:0] w;
    @(negedge clk);
    swMode = eSw;
    busAddr = a[31:1]; busData = d; busAm = am;
    {lnIack, lnIackIn, lnIackOut} = ib; lnWrite = wr; lnLword = lw;
    lnAs = 1; lnDs0 = ds[0]; lnDs1 = ds[1]; lnDtack = 0; lnBerr = 0;
    @(negedge clk);
    if (kind == 0 || kind == 3) lnDtack = 1;
    if (kind == 1) lnBerr = 1;
    if (kind == 0 || kind == 1) begin
      @(negedge clk);
      lnDs0 = 0; lnDs1 = 0; lnAs = 0;
      w = ctrlWordOf(ib, kind == 0, kind == 1, 1'b0, 1'b0, 1'b0, wr, lw, am);
      @(negedge clk);
      lnDtack = 0; lnBerr = 0; busAddr = ~a[31:1]; busData = ~d;
    end else if (kind == 2) begin
      w = ctrlWordOf(ib, 1'b0, 1'b0, 1'b1, ds[0], ds[1], wr, lw, am);
      @(negedge clk);
      lnDs0 = 0; lnDs1 = 0; lnAs = 0; busAddr = ~a[31:1]; busData = ~d;
    end else begin
      w = ctrlWordOf(ib, 1'b1, 1'b0, 1'b1, ds[0], ds[1], wr, lw, am);
      @(negedge clk);
      lnDtack = 0; busAddr = ~a[31:1]; busData = ~d;
      @(negedge clk);
      lnDs0 = 0; lnDs1 = 0; lnAs = 0;
    end
    if (!(eHalt || eCreg[7])) begin
      eAddr = {a[31:1], 1'b0};
      eData = d;
      eCtrl = w;
      if (kind == 1 && (eSw[2] | eCreg[2])) eHalt = 1'b1;
    end
    @(negedge clk);
  endtask

  task automatic ctrlWrite(input logic [7:0] v);
    @(negedge clk);
    ctrlWe = 1; ctrlWdata = v;
    @(negedge clk);
    ctrlWe = 0;
    eCreg = v & 8'h9F;
  endtask

  task automatic rhPulse(input int holdCycles);
    @(negedge clk);
    eSw[3] = 1'b1; swMode = eSw;
    @(negedge clk);
    eHalt = 1'b0;
    chk("reset-halt releases R6", {31'h0, haltActive}, {31'h0, eHalt});
    for (int i = 0; i < holdCycles; i++) @(negedge clk);
    eSw[3] = 1'b0; swMode = eSw;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired (all requirements) actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9: reset state
    checkAll("reset R9");
    chk("reset status R9", {16'h0, statusWord}, {16'h0, 16'h8000});
    @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 R3 R10: dtack cycle with odd address
    busCycle(0, 32'h1234_5679, 32'hCAFE_F00D, 6'h29, 3'b101, 1, 0, 2'b11);
    checkAll("dtack close R1");
    // R2: no acknowledge, single strobe
    busCycle(2, 32'h00AB_CDEF, 32'h5555_AAAA, 6'h3D, 3'b010, 0, 1, 2'b01);
    checkAll("strobe close R2");
    // R2: acknowledge released before strobes, must not capture twice
    busCycle(3, 32'hF0F0_0F0E, 32'h0123_4567, 6'h0D, 3'b000, 1, 1, 2'b10);
    checkAll("ack before strobe R2");
    // R5: berr without halt enable
    busCycle(1, 32'h8800_0010, 32'hDEAD_BEEF, 6'h2D, 3'b111, 0, 0, 2'b11);
    checkAll("berr no halt R5");

    // R4: software halt freezes
    ctrlWrite(8'h80);
    busCycle(0, 32'h1111_1111, 32'h2222_2222, 6'h01, 3'b001, 1, 1, 2'b11);
    checkAll("soft halt frozen R4");
    ctrlWrite(8'h00);

    // R5 R7: halt enable from control bit
    ctrlWrite(8'h04);
    chk("mode from control R7", {27'h0, modeEff}, {27'h0, eSw | eCreg[4:0]});
    busCycle(1, 32'h4444_4444, 32'h6666_6666, 6'h39, 3'b000, 1, 0, 2'b11);
    checkAll("berr halts R5");
    busCycle(0, 32'h7777_7776, 32'h9999_9999, 6'h3F, 3'b011, 0, 1, 2'b11);
    checkAll("hw halt frozen R4");
    ctrlWrite(8'h00);

    // R6: held request acts once; error under held request halts again
    eSw[2] = 1'b1;
    @(negedge clk);
    eSw[3] = 1'b1; swMode = eSw;
    @(negedge clk);
    eHalt = 1'b0;
    chk("release on rise R6", {31'h0, haltActive}, {31'h0, eHalt});
    busCycle(1, 32'hABCD_0000, 32'h0000_ABCD, 6'h09, 3'b100, 1, 1, 2'b11);
    checkAll("held request rehalt R6");
    repeat (4) @(negedge clk);
    chk("held request no release R6", {31'h0, haltActive}, 32'h1);
    eSw[3] = 1'b0; swMode = eSw;
    @(negedge clk);
    rhPulse(3);
    chk("after pulse armed R6", {31'h0, haltActive}, 32'h0);

    // R7: switch and control OR
    eSw = 5'b10010; swMode = eSw;
    ctrlWrite(8'hE9);
    chk("mode OR R7", {27'h0, modeEff}, {27'h0, eSw | eCreg[4:0]});
    chk("status bits R8 R7", {16'h0, statusWord}, {16'h0, 1'b1, 2'b00, eSw, eCreg});
    ctrlWrite(8'h00);
    eSw = 5'b00100; swMode = eSw;

    // R8: health combinations
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      {clkOk, p5Ok, p12Ok, n12Ok, p5Over} = 5'(i);
      #1;
      chk("status word R8", {16'h0, statusWord},
          {16'h0, (clkOk & p5Ok & p12Ok & n12Ok & ~p5Over), 2'b00, eSw, eCreg});
    end

    // Random transfers mixed with mode changes
    for (int it = 0; it < 120; it++) begin
      int r;
      r = int'($urandom % 16);
      if (r == 0) eSw[2] = ~eSw[2];
      if (r == 1) ctrlWrite(8'($urandom) & 8'h97);
      if (r == 2 && eHalt) rhPulse(int'($urandom % 3));
      begin
        logic [1:0] ds;
        ds = 2'($urandom % 3) + 2'd1;
        busCycle(int'($urandom % 4), $urandom, $urandom, 6'($urandom), 3'($urandom),
                 1'($urandom), 1'($urandom), ds);
      end
      checkAll("random R1 R2 R4 R5");
    end

    // R9: reset mid-run
    @(negedge clk);
    rstN = 0;
    #1;
    eAddr = '0; eData = '0; eCtrl = '0; eHalt = 0; eCreg = '0;
    checkAll("mid reset R9");
    chk("mid reset control R9", {24'h0, statusWord[7:0]}, 32'h0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule